// File: doc/BRIEF.md
# Bridge Configuration Request Router

This block sits at the upstream side of a bridge or switch port and decides what becomes of each configuration request that reaches it. A request names its target with a hierarchical bus / device / function identifier and is marked as either local-type (aimed at the segment it is on) or remote-type (aimed at some other segment). The block holds three programmable bus numbers: the upstream (primary) bus, the bus directly below the bridge (secondary) and the highest bus reachable below the bridge (subordinate).

Each request is given one of four outcomes. A local-type request is claimed for the bridge's own registers. A remote-type request whose bus equals the secondary number is rewritten into a local-type request for the downstream segment. A remote-type request whose bus lies above the secondary number and no higher than the subordinate number is passed downstream unchanged. Anything else is rejected as unsupported. Requests enter through a valid/ready port and leave, one cycle after acceptance, through a registered valid/ready port that also carries the outcome code.

Top module: `cfg_route`

## Requirements
- R1: After reset the three bus number outputs read zero and `out_valid` is low.
- R2: A write with `wr_en` high loads `wr_data` into the primary (`wr_sel`=0), secondary (`wr_sel`=1) or subordinate (`wr_sel`=2) register, visible on the matching output one cycle later; a write with `wr_sel`=3 changes no register.
- R3: A request with `in_kind`=0 (local-type) is emitted with `out_code`=0 (claim) and with its kind, bus, device and function unchanged.
- R4: A request with `in_kind`=1 (remote-type) whose bus equals a nonzero secondary number is emitted with `out_code`=1 (convert), `out_kind`=0, `out_bus`=0 and device and function unchanged.
- R5: A remote-type request whose bus is greater than the secondary number and less than or equal to the subordinate number (secondary nonzero) is emitted with `out_code`=2 (pass down) and all fields unchanged, including a bus exactly equal to subordinate.
- R6: A remote-type request whose bus is below the secondary number or above the subordinate number is emitted with `out_code`=3 (unsupported) and all fields unchanged.
- R7: While the secondary register holds zero, no request is given `out_code`=1 or `out_code`=2; a remote-type request, including one for bus 0, gets code 3.
- R8: An accepted request appears on the output one cycle after acceptance; while `out_valid` is high and `out_ready` is low the output holds stable and `in_ready` is low; a new request may be accepted in the same cycle an output is consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus number register write strobe |
| wr_sel | input | 2 | Register select: 0 primary, 1 secondary, 2 subordinate, 3 none |
| wr_data | input | BUS_W | Value to write |
| pri_bus | output | BUS_W | Current primary bus number |
| sec_bus | output | BUS_W | Current secondary bus number |
| sub_bus | output | BUS_W | Current subordinate bus number |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with `in_valid` |
| in_kind | input | 1 | 0 local-type, 1 remote-type |
| in_bus | input | BUS_W | Target bus |
| in_dev | input | DEV_W | Target device |
| in_fn | input | FN_W | Target function |
| out_valid | output | 1 | Routed request present |
| out_ready | input | 1 | Downstream takes the routed request |
| out_kind | output | 1 | Kind of the routed request |
| out_bus | output | BUS_W | Bus of the routed request |
| out_dev | output | DEV_W | Device of the routed request |
| out_fn | output | FN_W | Function of the routed request |
| out_code | output | 2 | 0 claim, 1 convert, 2 pass down, 3 unsupported |

## Verification
The bench builds the router with its default widths of 8, 5 and 3 bits for bus, device and function, so the full bus range 0 to 255 and the top values of device and function fields are reachable. With those widths it drives the window edges directly: one below secondary, secondary itself, one above, exactly subordinate and one above subordinate, plus the zero-secondary state where a bus-0 remote request would otherwise match. Back-pressure is applied by holding `out_ready` low across several cycles with a second request waiting.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  typedef enum logic [1:0] {
    RC_CLAIM    = 2'd0,
    RC_LOCALIZE = 2'd1,
    RC_PASS     = 2'd2,
    RC_REJECT   = 2'd3
  } route_code_e;

  localparam logic KIND_LOCAL  = 1'b0;
  localparam logic KIND_REMOTE = 1'b1;

  localparam int NUM_BUSREG = 3;
  localparam int SEL_W      = 2;

  localparam logic [SEL_W-1:0] SEL_PRI = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SEC = 2'd1;
  localparam logic [SEL_W-1:0] SEL_SUB = 2'd2;

endpackage

// File: rtl/cfg_busnum_regs.sv
module cfg_busnum_regs
  import cfg_route_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] pri_q,
  output logic [BUS_W-1:0] sec_q,
  output logic [BUS_W-1:0] sub_q
);

  logic [BUS_W-1:0] bank [NUM_BUSREG];

  for (genvar g = 0; g < NUM_BUSREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   bank[g] <= '0;
      else if (hit) bank[g] <= wr_data;
    end
  end

  assign pri_q = bank[SEL_PRI];
  assign sec_q = bank[SEL_SEC];
  assign sub_q = bank[SEL_SUB];

endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_route_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input  logic             i_kind,
  input  logic [BUS_W-1:0] i_bus,
  input  logic [DEV_W-1:0] i_dev,
  input  logic [FN_W-1:0]  i_fn,
  input  logic [BUS_W-1:0] sec,
  input  logic [BUS_W-1:0] sub,
  output route_code_e      o_code,
  output logic             o_kind,
  output logic [BUS_W-1:0] o_bus,
  output logic [DEV_W-1:0] o_dev,
  output logic [FN_W-1:0]  o_fn,
  output logic             down_en,
  output logic             hit_sec,
  output logic             in_window
);

  function automatic logic is_secondary(input logic [BUS_W-1:0] b,
                                        input logic [BUS_W-1:0] s);
    return b == s;
  endfunction

  function automatic logic is_below_bridge(input logic [BUS_W-1:0] b,
                                           input logic [BUS_W-1:0] s,
                                           input logic [BUS_W-1:0] top);
    return (b > s) && (b <= top);
  endfunction

  assign down_en   = (sec != '0);
  assign hit_sec   = is_secondary(i_bus, sec);
  assign in_window = is_below_bridge(i_bus, sec, sub);

  always_comb begin
    o_code = RC_CLAIM;
    o_kind = i_kind;
    o_bus  = i_bus;
    o_dev  = i_dev;
    o_fn   = i_fn;
    if (i_kind == KIND_LOCAL) begin
      o_code = RC_CLAIM;
    end else if (down_en && hit_sec) begin
      o_code = RC_LOCALIZE;
      o_kind = KIND_LOCAL;
      o_bus  = '0;
    end else if (down_en && in_window) begin
      o_code = RC_PASS;
    end else begin
      o_code = RC_REJECT;
    end
  end

endmodule

// File: rtl/cfg_route_stage.sv
module cfg_route_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  logic take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_route_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] pri_bus,
  output logic [BUS_W-1:0] sec_bus,
  output logic [BUS_W-1:0] sub_bus,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_kind,
  input  logic [BUS_W-1:0] in_bus,
  input  logic [DEV_W-1:0] in_dev,
  input  logic [FN_W-1:0]  in_fn,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_kind,
  output logic [BUS_W-1:0] out_bus,
  output logic [DEV_W-1:0] out_dev,
  output logic [FN_W-1:0]  out_fn,
  output logic [1:0]       out_code
);

  localparam int PAY_W = 2 + 1 + BUS_W + DEV_W + FN_W;

  route_code_e      dec_code;
  logic             dec_kind;
  logic [BUS_W-1:0] dec_bus;
  logic [DEV_W-1:0] dec_dev;
  logic [FN_W-1:0]  dec_fn;
  logic             down_en;
  logic             hit_sec;
  logic             in_window;
  logic             accept;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  cfg_busnum_regs #(.BUS_W(BUS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pri_q   (pri_bus),
    .sec_q   (sec_bus),
    .sub_q   (sub_bus)
  );

  cfg_route_decode #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W)) u_dec (
    .i_kind    (in_kind),
    .i_bus     (in_bus),
    .i_dev     (in_dev),
    .i_fn      (in_fn),
    .sec       (sec_bus),
    .sub       (sub_bus),
    .o_code    (dec_code),
    .o_kind    (dec_kind),
    .o_bus     (dec_bus),
    .o_dev     (dec_dev),
    .o_fn      (dec_fn),
    .down_en   (down_en),
    .hit_sec   (hit_sec),
    .in_window (in_window)
  );

  assign pay_in = {dec_code, dec_kind, dec_bus, dec_dev, dec_fn};

  cfg_route_stage #(.W(PAY_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign accept = in_valid && in_ready;
  assign {out_code, out_kind, out_bus, out_dev, out_fn} = pay_out;

endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             down_en,
  input logic             in_kind,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_kind,
  input logic [BUS_W-1:0] out_bus,
  input logic [DEV_W-1:0] out_dev,
  input logic [FN_W-1:0]  out_fn,
  input logic [1:0]       out_code
);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_kind)
      && $stable(out_bus) && $stable(out_dev) && $stable(out_fn));

  a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_accept_shows_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r4_convert_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == 2'd1 |-> out_kind == 1'b0 && out_bus == '0);

  a_r5_pass_is_remote: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == 2'd2 |-> out_kind == 1'b1);

  a_r3_local_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_kind == 1'b0 |=> out_code == 2'd0 && out_kind == 1'b0);

  a_r7_no_down_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !down_en |=> out_code != 2'd1 && out_code != 2'd2);

endmodule

bind cfg_route cfg_route_chk #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .down_en   (down_en),
  .in_kind   (in_kind),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_kind  (out_kind),
  .out_bus   (out_bus),
  .out_dev   (out_dev),
  .out_fn    (out_fn),
  .out_code  (out_code)
);

// File: tb/tb_cfg_route.sv
module tb_cfg_route;

  localparam int BW = 8;
  localparam int DW = 5;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [BW-1:0] wr_data = '0;
  logic [BW-1:0] pri_bus, sec_bus, sub_bus;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_kind = 1'b0;
  logic [BW-1:0] in_bus = '0;
  logic [DW-1:0] in_dev = '0;
  logic [FW-1:0] in_fn = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_kind;
  logic [BW-1:0] out_bus;
  logic [DW-1:0] out_dev;
  logic [FW-1:0] out_fn;
  logic [1:0]    out_code;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  cfg_route dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_bus(in_bus), .in_dev(in_dev), .in_fn(in_fn),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_bus(out_bus), .out_dev(out_dev), .out_fn(out_fn), .out_code(out_code)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model: outcome from kind, bus and current window.
  function automatic int model_code(input logic k, input int b, input int s, input int t);
    if (k == 1'b0) return 0;
    if (s == 0) return 3;
    if (b == s) return 1;
    if (b > s && b <= t) return 2;
    return 3;
  endfunction

  task automatic write_reg(input logic [1:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = BW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input string req, input logic k, input int b, input int d, input int f);
    int ec;
    ec = model_code(k, b, sec_bus, sub_bus);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_bus = BW'(b); in_dev = DW'(d); in_fn = FW'(f);
    check(req, "in_ready before accept", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", out_valid, 1);
    check(req, "out_code", out_code, ec);
    check(req, "out_kind", out_kind, (ec == 1) ? 0 : k);
    check(req, "out_bus", out_bus, (ec == 1) ? 0 : b);
    check(req, "out_dev", out_dev, d);
    check(req, "out_fn", out_fn, f);
  endtask

  task automatic t_reset;
    check("R1", "pri_bus", pri_bus, 0);
    check("R1", "sec_bus", sec_bus, 0);
    check("R1", "sub_bus", sub_bus, 0);
    check("R1", "out_valid", out_valid, 0);
  endtask

  task automatic t_zero_secondary;
    send("R7", 1'b1, 0, 4, 1);   // bus 0 equals secondary 0 but must not convert
    send("R7", 1'b1, 7, 2, 2);
  endtask

  task automatic t_program;
    write_reg(2'd0, 1);
    check("R2", "pri_bus", pri_bus, 1);
    write_reg(2'd1, 2);
    check("R2", "sec_bus", sec_bus, 2);
    write_reg(2'd2, 5);
    check("R2", "sub_bus", sub_bus, 5);
    write_reg(2'd3, 9);          // reserved select ignored
    check("R2", "pri_bus after sel3", pri_bus, 1);
    check("R2", "sec_bus after sel3", sec_bus, 2);
    check("R2", "sub_bus after sel3", sub_bus, 5);
  endtask

  task automatic t_routes;
    send("R3", 1'b0, 9, 31, 7);
    send("R4", 1'b1, 2, 17, 5);
    send("R5", 1'b1, 3, 1, 0);
    send("R5", 1'b1, 5, 30, 6);   // top of window
    send("R6", 1'b1, 6, 3, 3);    // one past subordinate
    send("R6", 1'b1, 1, 3, 4);    // below secondary
    send("R6", 1'b1, 255, 0, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_kind = 1'b1; in_bus = 8'd4; in_dev = 5'd9; in_fn = 3'd1;
    @(negedge clk);
    check("R8", "out_valid after accept", out_valid, 1);
    check("R8", "in_ready while stalled", in_ready, 0);
    in_kind = 1'b0; in_bus = 8'd77; in_dev = 5'd12; in_fn = 3'd2;
    repeat (3) @(negedge clk);
    check("R8", "held code", out_code, 2);
    check("R8", "held bus", out_bus, 4);
    check("R8", "held dev", out_dev, 9);
    check("R8", "in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "second out_valid", out_valid, 1);
    check("R8", "second code", out_code, 0);
    check("R8", "second bus", out_bus, 77);
    check("R8", "second dev", out_dev, 12);
    @(negedge clk);
    check("R8", "drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_secondary();
    t_program();
    t_routes();
    t_backpressure();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule